// File: doc/BRIEF.md
# Half-Width Immediate Trap Condition Evaluator

This block decides whether a conditional trap fires. The operand is the lower half of a general register whose width, XLEN, is a parameter. That half is sign-extended. It is then compared against a 16-bit signed immediate under a 5-bit condition mask. The operand is half the register width rather than a fixed 32-bit word, so a narrow core (XLEN=8) tests a 4-bit nibble. Even then, the immediate keeps all of its 16 significant bits.

Both values are widened to one common width, max(XLEN/2, 16) + 1 bits, before any comparison. At that width no relation overflows and the immediate is never truncated. The trap request itself is combinational. When the registered option is enabled, a copy delayed by one clock cycle is also provided, so that clocked pipelines can take the result from a flop. Exception entry, redirecting the program counter and instruction decode all belong to the surrounding core.

Top module: `halfw_trap_eval`

## Requirements
- R1: The compared operand is bits [XLEN/2-1:0] of `reg_val_i`, sign-extended from bit XLEN/2-1. The bits above XLEN/2-1 have no effect on either trap output.
- R2: `imm_i` is treated as a 16-bit two's-complement value and keeps all 16 bits at every XLEN. With XLEN=8, a nibble of +7 against an immediate of 100 counts as less-than.
- R3: Mask bit 0 requests a trap when the operand is less than the immediate as signed values.
- R4: Mask bit 1 requests a trap when the operand is greater than the immediate as signed values.
- R5: Mask bit 2 requests a trap when the operand equals the immediate.
- R6: Mask bit 3 requests a trap when the sign-extended operand is below the sign-extended immediate, both read as unsigned numbers at the common width.
- R7: Mask bit 4 requests a trap when the sign-extended operand is above the sign-extended immediate, both read as unsigned numbers at the common width.
- R8: `trap_o` is the OR of every mask bit whose condition holds. A mask of zero never traps. A mask with bits 2:0 all set always traps.
- R9: With REG_OUT=1, `trap_q_o` equals the value `trap_o` had one rising edge earlier. While `rst_ni` is low, `trap_q_o` is 0.
- R10: For any input, exactly one of the signed relations less, equal and greater holds. Equality excludes both unsigned relations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the registered trap copy |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_val_i | input | XLEN | Register operand; only the low half is used |
| imm_i | input | 16 | Signed immediate |
| cond_mask_i | input | 5 | Condition enables: bit0 slt, bit1 sgt, bit2 eq, bit3 ult, bit4 ugt |
| trap_o | output | 1 | Combinational trap request |
| trap_q_o | output | 1 | Trap request delayed by one clock (or `trap_o` when REG_OUT=0) |

## Verification
The assertions assume that the operand, immediate and mask are stable and known at each rising clock edge once reset has been released. They also assume that reset is held for at least one edge, so the registered copy begins from a known 0. The bench meets these assumptions by changing every input only on falling edges and by keeping reset low over two rising edges before it applies any stimulus. Two instances are exercised together, one with XLEN=64 and one with XLEN=8. The narrow instance receives the low byte of the same register value, so the nibble case meets the same immediates as the 32-bit half.

// File: rtl/hw_trap_pkg.sv
package hw_trap_pkg;

   localparam int NUM_COND = 5;

   // condition indices; these match the mask bit positions
   localparam int C_SLT = 0;
   localparam int C_SGT = 1;
   localparam int C_EQ  = 2;
   localparam int C_ULT = 3;
   localparam int C_UGT = 4;

   typedef logic [NUM_COND-1:0] cond_vec_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hw_trap_sext.sv
module hw_trap_sext #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 17
) (
   input  logic [IN_W-1:0]  val_i,
   output logic [OUT_W-1:0] val_o
);
   localparam int PAD_W = OUT_W - IN_W;

   initial begin
      if (IN_W < 1)      $error("hw_trap_sext: IN_W must be positive");
      if (OUT_W < IN_W)  $error("hw_trap_sext: OUT_W below IN_W");
   end

   generate
      if (PAD_W == 0) begin : g_pass
         assign val_o = val_i;
      end else begin : g_pad
         assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
      end
   endgenerate
endmodule

// File: rtl/hw_trap_cmp.sv
module hw_trap_cmp
   import hw_trap_pkg::*;
#(
   parameter int W = 17
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output cond_vec_t    flags_o
);
   logic s_lt, s_gt, u_lt, u_gt, same;

   always_comb begin
      s_lt = $signed(a_i) < $signed(b_i);
      s_gt = $signed(a_i) > $signed(b_i);
      u_lt = a_i < b_i;
      u_gt = a_i > b_i;
      same = a_i == b_i;
   end

   always_comb begin
      flags_o        = '0;
      flags_o[C_SLT] = s_lt;
      flags_o[C_SGT] = s_gt;
      flags_o[C_EQ]  = same;
      flags_o[C_ULT] = u_lt;
      flags_o[C_UGT] = u_gt;
   end
endmodule

// File: rtl/hw_trap_combine.sv
module hw_trap_combine
   import hw_trap_pkg::*;
(
   input  cond_vec_t flags_i,
   input  cond_vec_t mask_i,
   output logic      trap_o
);
   cond_vec_t hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_COND; gi++) begin : g_hit
         assign hit[gi] = flags_i[gi] & mask_i[gi];
      end
   endgenerate

   assign trap_o = |hit;
endmodule

// File: rtl/halfw_trap_eval.sv
module halfw_trap_eval
   import hw_trap_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int IMM_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [XLEN-1:0]     reg_val_i,
   input  logic [IMM_W-1:0]    imm_i,
   input  logic [NUM_COND-1:0] cond_mask_i,
   output logic                trap_o,
   output logic                trap_q_o
);
   localparam int HALF_W = XLEN / 2;
   localparam int CMP_W  = max_int(HALF_W, IMM_W) + 1;

   initial begin
      if (XLEN < 2)         $error("halfw_trap_eval: XLEN too small");
      if ((XLEN % 2) != 0)  $error("halfw_trap_eval: XLEN must be even");
      if (IMM_W < 2)        $error("halfw_trap_eval: IMM_W too small");
   end

   logic [HALF_W-1:0] half_op;
   logic [CMP_W-1:0]  op_ext;
   logic [CMP_W-1:0]  imm_ext;
   cond_vec_t         cond_flags;
   logic              trap_now;

   assign half_op = reg_val_i[HALF_W-1:0];

   hw_trap_sext #(.IN_W(HALF_W), .OUT_W(CMP_W)) u_op_ext (
      .val_i (half_op),
      .val_o (op_ext)
   );

   hw_trap_sext #(.IN_W(IMM_W), .OUT_W(CMP_W)) u_imm_ext (
      .val_i (imm_i),
      .val_o (imm_ext)
   );

   hw_trap_cmp #(.W(CMP_W)) u_cmp (
      .a_i     (op_ext),
      .b_i     (imm_ext),
      .flags_o (cond_flags)
   );

   hw_trap_combine u_comb (
      .flags_i (cond_flags),
      .mask_i  (cond_mask_i),
      .trap_o  (trap_now)
   );

   assign trap_o = trap_now;

   generate
      if (REG_OUT) begin : g_reg
         logic trap_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) trap_q <= 1'b0;
            else         trap_q <= trap_now;
         end
         assign trap_q_o = trap_q;
      end else begin : g_comb
         assign trap_q_o = trap_now;
      end
   endgenerate
endmodule

// File: rtl/hw_trap_eval_chk.sv
module hw_trap_eval_chk
   import hw_trap_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input logic      clk_i,
   input logic      rst_ni,
   input cond_vec_t cond_mask_i,
   input cond_vec_t flags_i,
   input logic      trap_o,
   input logic      trap_q_o
);
   p_zero_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_mask_i == '0) |-> !trap_o);

   p_full_signed_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_mask_i[2:0] == 3'b111) |-> trap_o);

   p_signed_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({flags_i[C_SLT], flags_i[C_EQ], flags_i[C_SGT]}) == 1);

   p_eq_not_unsigned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_i[C_EQ] |-> !(flags_i[C_ULT] | flags_i[C_UGT]));

   p_eq_traps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[C_EQ] && cond_mask_i[C_EQ]) |-> trap_o);

   p_slt_traps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[C_SLT] && cond_mask_i[C_SLT]) |-> trap_o);

   p_sgt_traps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[C_SGT] && cond_mask_i[C_SGT]) |-> trap_o);

   p_ult_traps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[C_ULT] && cond_mask_i[C_ULT]) |-> trap_o);

   p_ugt_traps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[C_UGT] && cond_mask_i[C_UGT]) |-> trap_o);

   generate
      if (REG_OUT) begin : g_reg_chk
         p_pulse_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rst_ni |=> (trap_q_o == $past(trap_o)));
      end
   endgenerate
endmodule

bind halfw_trap_eval hw_trap_eval_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cond_mask_i (cond_mask_i),
   .flags_i     (cond_flags),
   .trap_o      (trap_o),
   .trap_q_o    (trap_q_o)
);

// File: tb/halfw_trap_eval_bench.sv
module halfw_trap_eval_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] reg_val = '0;
   logic [15:0] imm = '0;
   logic [4:0]  mask = '0;
   logic        trap_w, trapq_w, trap_n, trapq_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   halfw_trap_eval #(.XLEN(64)) u_halfw_trap_eval (
      .clk_i (clk), .rst_ni (rst_n), .reg_val_i (reg_val), .imm_i (imm),
      .cond_mask_i (mask), .trap_o (trap_w), .trap_q_o (trapq_w));

   halfw_trap_eval #(.XLEN(8)) u_halfw_trap_eval_x8 (
      .clk_i (clk), .rst_ni (rst_n), .reg_val_i (reg_val[7:0]), .imm_i (imm),
      .cond_mask_i (mask), .trap_o (trap_n), .trap_q_o (trapq_n));

   function automatic logic exp_trap(input int xlen, input logic [63:0] r,
                                     input logic [15:0] im, input logic [4:0] m);
      int half = xlen / 2;
      logic [63:0] a;
      logic [63:0] b;
      logic slt, sgt, eq, ult, ugt;
      for (int i = 0; i < 64; i++) a[i] = (i < half) ? r[i] : r[half-1];
      b   = {{48{im[15]}}, im};
      slt = $signed(a) < $signed(b);
      sgt = $signed(a) > $signed(b);
      eq  = a == b;
      ult = a < b;
      ugt = a > b;
      return (m[0] & slt) | (m[1] & sgt) | (m[2] & eq) | (m[3] & ult) | (m[4] & ugt);
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // drives on a falling edge, checks comb outputs, then the registered copies
   task automatic apply(input string req, input logic [63:0] r,
                        input logic [15:0] im, input logic [4:0] m);
      logic e64, e8;
      @(negedge clk);
      reg_val = r; imm = im; mask = m;
      e64 = exp_trap(64, r, im, m);
      e8  = exp_trap(8, r, im, m);
      #1;
      check(req, "trap x64", trap_w, e64);
      check(req, "trap x8", trap_n, e8);
      @(posedge clk);
      #1;
      check("R9", "trap_q x64", trapq_w, e64);
      check("R9", "trap_q x8", trapq_n, e8);
   endtask

   task automatic t_reset;
      #1;
      check("R9", "reset trap_q x64", trapq_w, 1'b0);
      check("R9", "reset trap_q x8", trapq_n, 1'b0);
   endtask

   task automatic t_signed_rel;
      apply("R3", 64'h0000_0000_FFFF_FFFF, 16'h0001, 5'b00001); // -1 < 1
      apply("R3", 64'h0000_0000_0000_0005, 16'hFFFD, 5'b00001); // 5 < -3 no
      apply("R4", 64'h0000_0000_0000_0005, 16'hFFFD, 5'b00010);
      apply("R4", 64'h0000_0000_8000_0000, 16'h7FFF, 5'b00010);
      check("R4", "x64 most negative not above", trap_w, 1'b0);
   endtask

   task automatic t_equal;
      apply("R5", 64'h0000_0000_FFFF_8000, 16'h8000, 5'b00100);
      check("R5", "x64 eq after extension", trap_w, 1'b1);
      apply("R5", 64'h0000_0000_0000_8000, 16'h8000, 5'b00100);
      check("R5", "x64 positive vs negative", trap_w, 1'b0);
   endtask

   task automatic t_unsigned;
      apply("R6", 64'h0000_0000_FFFF_FFFF, 16'h0001, 5'b01000);
      check("R6", "x64 -1 not unsigned below 1", trap_w, 1'b0);
      apply("R7", 64'h0000_0000_FFFF_FFFF, 16'h0001, 5'b10000);
      check("R7", "x64 -1 unsigned above 1", trap_w, 1'b1);
      apply("R6", 64'h0000_0000_0000_0002, 16'hFFF0, 5'b01000);
   endtask

   task automatic t_upper_ignored;
      apply("R1", 64'hDEAD_BEEF_0000_0003, 16'h0003, 5'b00100);
      check("R1", "x64 upper bits ignored", trap_w, 1'b1);
      apply("R1", 64'h1234_5678_9ABC_DEF3, 16'h0003, 5'b00100);
   endtask

   task automatic t_nibble;
      apply("R2", 64'h0000_0000_0000_00F7, 16'd100, 5'b00001);
      check("R2", "x8 nibble 7 below 100", trap_n, 1'b1);
      apply("R2", 64'h0000_0000_0000_0008, 16'hFFF8, 5'b00100);
      check("R2", "x8 nibble -8 equals -8", trap_n, 1'b1);
      apply("R2", 64'h0000_0000_0000_0007, 16'h0017, 5'b00100);
      check("R2", "x8 no truncation of imm", trap_n, 1'b0);
   endtask

   task automatic t_masks;
      apply("R8", 64'h0000_0000_FFFF_FFFF, 16'h0001, 5'b00000);
      check("R8", "x64 zero mask", trap_w, 1'b0);
      apply("R8", 64'h0000_0000_0000_0042, 16'hABCD, 5'b00111);
      check("R8", "x64 all signed", trap_w, 1'b1);
      apply("R8", 64'h0000_0000_0000_0004, 16'h0004, 5'b11011);
      check("R8", "x64 eq excluded", trap_w, 1'b0);
      apply("R10", 64'h0000_0000_0000_0004, 16'h0004, 5'b11111);
   endtask

   task automatic t_pulse_drop;
      apply("R9", 64'h0, 16'h0, 5'b00100);
      apply("R9", 64'h0, 16'h1, 5'b00100);
      check("R9", "x64 trap_q falls", trapq_w, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_signed_rel();
      t_equal();
      t_unsigned();
      t_upper_ignored();
      t_nibble();
      t_masks();
      t_pulse_drop();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule